// File: doc/BRIEF.md
# Oversampled SPI Slave Receiver/Transmitter

This block is an SPI slave that lives entirely in the system clock domain. The serial clock, data-in and select pins are never used as clocks. They pass through two-flop synchronisers, and the edges of the serial clock are found by comparing successive synchronised samples. Each detected rising edge samples one data bit, and each detected falling edge moves the next transmit bit onto the data-out pin. Bits travel most significant first, with the clock idling low.

While select is high the block sleeps. The data-out driver is disabled, serial clock activity is ignored, and software may preload the byte to send. Once select goes low, eight rising edges complete a byte. The received byte is then copied into a read buffer, a completion flag is set, and an interrupt is raised if interrupts are enabled. If software has not taken the previous byte before the next one completes, a sticky overrun flag is set and the earlier byte is lost.

Top module: `spi_slave_os`

## Requirements
- R1: While the synchronised select is high, `miso_oe_o` is 0 and serial clock edges are not counted. `miso_oe_o` goes to 1 on the third clock edge after `sel_n_i` falls.
- R2: The transmit byte goes out most significant bit first. Its bit 7 is on `miso_o` before the first rising serial clock edge, and each later bit appears on the third clock edge after a falling `sck_i` edge.
- R3: `mosi_i` is sampled on rising serial clock edges, most significant bit first. On the third clock edge after the eighth rising `sck_i` edge, `rx_data_o` holds the byte and `done_o` is 1.
- R4: `irq_o` is 1 exactly while `done_o` is 1 and `irq_en_i` was 1 at the preceding clock edge. With `irq_en_i` at 0 it stays 0.
- R5: A one-cycle `rx_read_i` pulse clears `done_o` on that clock edge. If a byte completes on the same edge, `done_o` stays set.
- R6: If a byte completes while `done_o` is set and no read arrives on that edge, `ovr_o` goes to 1 and `rx_data_o` takes the new byte. `ovr_o` then stays 1 until reset, even after reads.
- R7: When select rises in the middle of a byte, the partial bits are discarded. The next transfer starts from bit 7 again.
- R8: A `tx_load_i` pulse stores `tx_data_i` only while the bit count is zero, that is while deselected or between bytes. A load in the middle of a byte is ignored.
- R9: After reset, `miso_o`, `miso_oe_o`, `rx_data_o`, `done_o`, `irq_o` and `ovr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| mosi_i | input | 1 | Serial data from the master, asynchronous |
| sel_n_i | input | 1 | Active-low select pin, asynchronous |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the `miso_o` pad driver |
| tx_data_i | input | DW | Byte to transmit |
| tx_load_i | input | 1 | Strobe that stores `tx_data_i` |
| irq_en_i | input | 1 | Interrupt enable |
| rx_read_i | input | 1 | Strobe that acknowledges the buffered byte |
| rx_data_o | output | DW | Last completed received byte |
| done_o | output | 1 | Transfer-complete flag |
| irq_o | output | 1 | Interrupt request |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Every pin-driven result is due on the third clock edge after the pin changes: two synchroniser stages, then one state register. This covers the output enable after select falls, the next data-out bit after a falling clock, and the buffered byte with its flag after the eighth rising clock. The bench changes pins on falling clock edges and counts exactly three rising edges before it samples. For the completion flag it also samples one edge earlier to confirm the flag is not yet set. Read and load strobes act on the next rising edge, so their effects are checked on the falling edge that follows.

// File: rtl/spis_pkg.sv
package spis_pkg;
  typedef struct packed {
    logic sel_n;
    logic sck;
    logic mosi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sck: 1'b0, mosi: 1'b0};
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_act_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mosi_i,
  input  logic          tx_load_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          byte_done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          miso_o
);
  localparam int            CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] rxsr;
  logic [DW-1:0] txsr;
  logic          cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign byte_done_o = sel_act_i & rise_i & (cnt == LAST);
  assign rx_word_o   = {rxsr[DW-2:0], mosi_i};
  assign miso_o      = txsr[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      rxsr <= '0;
      txsr <= '0;
    end else if (!sel_act_i) begin
      cnt  <= '0;
      rxsr <= '0;
      if (tx_load_i) txsr <= tx_data_i;
    end else begin
      if (rise_i) begin
        rxsr <= {rxsr[DW-2:0], mosi_i};
        cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
      if (fall_i && !cnt_zero)                 txsr <= {txsr[DW-2:0], 1'b0};
      else if (tx_load_i && cnt_zero && !rise_i) txsr <= tx_data_i;
    end
  end

  // R8: mid-byte, the transmit register only moves on a falling edge
  p_no_mid_load_r8: assert property (@(posedge clk) disable iff (rst)
    (sel_act_i && !cnt_zero && !fall_i) |=> $stable(txsr));

  // R1: while deselected the bit count stays at zero
  p_idle_count_r1: assert property (@(posedge clk) disable iff (rst)
    (!sel_act_i && $past(!sel_act_i)) |-> cnt_zero);
endmodule

// File: rtl/spi_slave_os.sv
module spi_slave_os #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          sel_n_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_load_i,
  input  logic          irq_en_i,
  input  logic          rx_read_i,
  output logic [DW-1:0] rx_data_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          ovr_o
);
  import spis_pkg::*;

  pins_t         raw_pins, s_pins;
  logic          sel_act, rise, fall, byte_done, done_n;
  logic [DW-1:0] rx_word;

  assign raw_pins = '{sel_n: sel_n_i, sck: sck_i, mosi: mosi_i};

  spis_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_pins), .q_o(s_pins)
  );

  assign sel_act = ~s_pins.sel_n;

  spis_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(s_pins.sck), .rise_o(rise), .fall_o(fall)
  );

  spis_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .sel_act_i(sel_act), .rise_i(rise), .fall_i(fall),
    .mosi_i(s_pins.mosi), .tx_load_i(tx_load_i), .tx_data_i(tx_data_i),
    .byte_done_o(byte_done), .rx_word_o(rx_word), .miso_o(miso_o)
  );

  assign done_n = byte_done | (done_o & ~rx_read_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_o <= '0;
      done_o    <= 1'b0;
      irq_o     <= 1'b0;
      ovr_o     <= 1'b0;
      miso_oe_o <= 1'b0;
    end else begin
      miso_oe_o <= sel_act;
      done_o    <= done_n;
      irq_o     <= done_n & irq_en_i;
      if (byte_done) begin
        rx_data_o <= rx_word;
        if (done_o && !rx_read_i) ovr_o <= 1'b1;
      end
    end
  end

  // R4: no interrupt without a pending byte
  p_irq_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> done_o);

  // R6: overrun is sticky
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovr_o |=> ovr_o);

  // R5: a read with no completing byte clears the flag
  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && rx_read_i && !byte_done) |=> !done_o);

  // R3: the flag only rises from a completed byte
  p_done_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(byte_done));
endmodule

// File: tb/sim_spi_slave_os.sv
module sim_spi_slave_os;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0, mosi = 1'b0, sel_n = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_load = 1'b0, irq_en = 1'b0, rx_read = 1'b0;
  logic       miso, miso_oe, done, irq, ovr;
  logic [7:0] rx_data, got;
  int         n_chk = 0, n_fail = 0;
  bit         ended = 1'b0;

  always #10 clk = ~clk;

  spi_slave_os u0 (
    .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .tx_data_i(tx_data), .tx_load_i(tx_load),
    .irq_en_i(irq_en), .rx_read_i(rx_read), .rx_data_o(rx_data),
    .done_o(done), .irq_o(irq), .ovr_o(ovr)
  );

  // {tx byte, byte on mosi, irq enable}
  localparam logic [16:0] VEC [6] = '{
    {8'hA5, 8'h5A, 1'b1}, {8'h00, 8'hFF, 1'b0}, {8'hFF, 8'h00, 1'b1},
    {8'h81, 8'h7E, 1'b1}, {8'h3C, 8'hC3, 1'b0}, {8'h96, 8'h01, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sel_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    tx_load = 1'b0; rx_read = 1'b0; irq_en = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic load(input logic [7:0] b);
    tx_data = b; tx_load = 1'b1; tick(1); tx_load = 1'b0;
  endtask

  task automatic read_rx();
    rx_read = 1'b1; tick(1); rx_read = 1'b0;
  endtask

  task automatic sel_on();
    sel_n = 1'b0; tick(4);
  endtask

  task automatic sel_off();
    sel_n = 1'b1; tick(4);
  endtask

  task automatic sbit(input logic b, output logic m);
    mosi = b; m = miso;
    sck = 1'b1; tick(HALF);
    sck = 1'b0; tick(HALF);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) sbit(mo[i], mi[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: reset state
    chk("R9 miso", miso, 0);     chk("R9 oe", miso_oe, 0);
    chk("R9 rx", rx_data, 0);    chk("R9 done", done, 0);
    chk("R9 irq", irq, 0);       chk("R9 ovr", ovr, 0);

    // Table walk: R1 R2 R3 R4 R5
    foreach (VEC[k]) begin
      irq_en = VEC[k][0];
      load(VEC[k][16:9]);
      sel_n = 1'b0;
      tick(2); chk("R1 oe early", miso_oe, 0);
      tick(1); chk("R1 oe on", miso_oe, 1);
      tick(1);
      xfer(VEC[k][8:1], got);
      chk("R3 rx", rx_data, VEC[k][8:1]);
      chk("R2 miso", got, VEC[k][16:9]);
      chk("R3 done", done, 1);
      chk("R4 irq", irq, VEC[k][0]);
      chk("R6 no ovr", ovr, 0);
      sel_off();
      chk("R1 oe off", miso_oe, 0);
      read_rx();
      chk("R5 done cleared", done, 0);
      chk("R4 irq cleared", irq, 0);
    end

    // R1: clock pulses while deselected are not counted
    for (int i = 0; i < 5; i++) sbit(1'b1, got[0]);
    chk("R1 no done", done, 0);
    sel_on();
    xfer(8'h3C, got);
    chk("R1 aligned", rx_data, 8'h3C);
    sel_off(); read_rx();

    // R7: partial byte discarded on select rise
    sel_on();
    for (int i = 0; i < 3; i++) sbit(1'b1, got[0]);
    sel_off();
    chk("R7 no done", done, 0);
    sel_on();
    xfer(8'h5A, got);
    chk("R7 realigned", rx_data, 8'h5A);
    chk("R7 done", done, 1);
    read_rx();

    // R8 mid-byte load ignored, then R2 load between bytes
    sel_off();
    load(8'hF0);
    sel_on();
    sbit(1'b0, got[7]); sbit(1'b0, got[6]);
    load(8'h0F);
    for (int i = 5; i >= 0; i--) sbit(1'b0, got[i]);
    chk("R8 load ignored", got, 8'hF0);
    read_rx();
    load(8'h81);
    chk("R2 msb preload", miso, 1);
    xfer(8'h11, got);
    chk("R2 back to back", got, 8'h81);
    chk("R3 back to back rx", rx_data, 8'h11);
    read_rx();

    // R3 exact latency of the completion flag
    for (int i = 7; i >= 1; i--) sbit(1'b1, got[0]);
    mosi = 1'b0; sck = 1'b1;
    tick(2); chk("R3 done not yet", done, 0);
    tick(1); chk("R3 done due", done, 1);
    chk("R3 latency rx", rx_data, 8'hFE);
    sck = 1'b0; tick(HALF);

    // R5: read on the same edge a byte completes keeps the flag
    for (int i = 7; i >= 1; i--) sbit(1'b0, got[0]);
    mosi = 1'b1; sck = 1'b1;
    tick(2); rx_read = 1'b1; tick(1); rx_read = 1'b0;
    chk("R5 set wins", done, 1);
    chk("R6 no ovr on read edge", ovr, 0);
    sck = 1'b0; tick(HALF);
    read_rx();

    // R6 overrun
    xfer(8'h22, got);
    xfer(8'h44, got);
    chk("R6 ovr set", ovr, 1);
    chk("R6 new byte", rx_data, 8'h44);
    read_rx();
    chk("R6 ovr sticky", ovr, 1);
    chk("R5 done after read", done, 0);
    sel_off();

    ended = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule